// File: doc/BRIEF.md
# In-Order Dual-Issue Pairing Stage

This block sits at the issue point of a small in-order pipeline. Each cycle it examines the two oldest decoded instructions, an older slot and a younger slot, and decides whether nothing issues, only the older instruction issues, or both issue together. Each slot carries a valid bit, a class code, one destination register index and two source register indexes.

Whether two instructions may pair depends on a class table in which the older and younger positions are treated differently. A register dependency check also runs between the two slots. The block returns a count of consumed entries to the decode buffer. When only the older instruction leaves, the held younger one becomes the older slot on the next cycle and is judged again against whatever follows it. A stall input suppresses all issue.

Top module: `dual_issue_pair`

## Requirements
- R1: At most two instructions issue per cycle and always in order. The younger strobe is never high without the older strobe. `consume_o` equals the number of strobes that are high and is never 3.
- R2: While `stall_i` is high, while the older slot is invalid, or while `rst_ni` is low, both strobes are low and `consume_o` is 0. An invalid younger slot with a valid older one gives a single issue.
- R3: Class codes are 0 = other, 1 = direct branch, 2 = call, 3 = ALU with an immediate operand, 4 = ALU with register operands. Codes 5 to 7 are treated as other. A direct branch pairs with an immediate ALU in either position.
- R4: Two branch-type instructions (direct branch or call, in any order) never issue together.
- R5: A call never issues as the older instruction of a pair. A call may issue as the younger instruction behind an immediate ALU.
- R6: A register-operand ALU pairs only as the older instruction, and only with an immediate ALU behind it. It never issues as the younger instruction of a pair. An immediate ALU may pair with an immediate ALU, a branch or a call behind it.
- R7: An instruction of class other always issues alone, in either slot.
- R8: Every class except direct branch writes its destination index. The younger instruction is held when either of its source indexes equals the destination of a writing older instruction. The destination field of a direct branch is ignored.
- R9: The younger instruction is held when both instructions write the same destination index.
- R10: A younger instruction that is held issues on a later cycle, once the decode buffer presents it as the older slot, without any further wait. This includes an instruction that reads the link register written by a call issued on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Suppress all issue this cycle |
| old_vld_i | input | 1 | Older slot holds an instruction |
| old_cls_i | input | 3 | Older class code |
| old_dst_i | input | REG_W | Older destination index |
| old_src0_i | input | REG_W | Older first source index |
| old_src1_i | input | REG_W | Older second source index |
| yng_vld_i | input | 1 | Younger slot holds an instruction |
| yng_cls_i | input | 3 | Younger class code |
| yng_dst_i | input | REG_W | Younger destination index |
| yng_src0_i | input | REG_W | Younger first source index |
| yng_src1_i | input | REG_W | Younger second source index |
| iss_old_o | output | 1 | Older instruction issues |
| iss_yng_o | output | 1 | Younger instruction issues |
| consume_o | output | 2 | Entries taken from the decode buffer |

## Verification
A wrong entry in the class table or a missed register match shows up at the ports in the same cycle. The younger strobe rises for a forbidden pair, or it stays low for a legal one, and `consume_o` moves with it. If that happens in a pipelined sequence, the decode buffer advances by the wrong amount. The next cycle then presents the wrong older instruction, so one wrong decision shifts every later decision in the sequence. The directed scenarios cover each cell of the class table and each dependency pattern. A randomized pass compares every cycle against an independent table model.

// File: rtl/dip_pkg.sv
package dip_pkg;
  typedef enum logic [2:0] {
    CLS_OTHER   = 3'd0,
    CLS_BRANCH  = 3'd1,
    CLS_CALL    = 3'd2,
    CLS_ALU_IMM = 3'd3,
    CLS_ALU_REG = 3'd4
  } cls_e;

  // unknown codes behave as "other"
  function automatic cls_e decode_cls(input logic [2:0] code);
    case (code)
      3'd1:    return CLS_BRANCH;
      3'd2:    return CLS_CALL;
      3'd3:    return CLS_ALU_IMM;
      3'd4:    return CLS_ALU_REG;
      default: return CLS_OTHER;
    endcase
  endfunction

  function automatic logic is_flow(input cls_e c);
    return (c == CLS_BRANCH) || (c == CLS_CALL);
  endfunction

  function automatic logic writes_dst(input cls_e c);
    return c != CLS_BRANCH;
  endfunction
endpackage

// File: rtl/dip_class_rule.sv
module dip_class_rule
  import dip_pkg::*;
(
  input  cls_e old_cls_i,
  input  cls_e yng_cls_i,
  output logic pair_ok_o
);
  // rows: older position, columns: younger position
  always_comb begin
    pair_ok_o = 1'b0;
    unique case (old_cls_i)
      CLS_ALU_IMM: pair_ok_o = (yng_cls_i == CLS_ALU_IMM) ||
                               (yng_cls_i == CLS_BRANCH)  ||
                               (yng_cls_i == CLS_CALL);
      CLS_ALU_REG: pair_ok_o = (yng_cls_i == CLS_ALU_IMM);
      CLS_BRANCH:  pair_ok_o = (yng_cls_i == CLS_ALU_IMM);
      CLS_CALL:    pair_ok_o = 1'b0;
      default:     pair_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dip_hazard.sv
module dip_hazard #(
  parameter int unsigned REG_W = 5
) (
  input  logic             old_wr_i,
  input  logic [REG_W-1:0] old_dst_i,
  input  logic             yng_wr_i,
  input  logic [REG_W-1:0] yng_dst_i,
  input  logic [REG_W-1:0] yng_src0_i,
  input  logic [REG_W-1:0] yng_src1_i,
  output logic             raw_o,
  output logic             waw_o
);
  localparam int unsigned NSRC = 2;
  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic [NSRC-1:0]            hit;

  assign srcs = {yng_src1_i, yng_src0_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = old_wr_i && (srcs[g] == old_dst_i);
  end

  assign raw_o = |hit;
  assign waw_o = old_wr_i && yng_wr_i && (yng_dst_i == old_dst_i);
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic             old_vld_i,
  input  logic [2:0]       old_cls_i,
  input  logic [REG_W-1:0] old_dst_i,
  input  logic [REG_W-1:0] old_src0_i,
  input  logic [REG_W-1:0] old_src1_i,
  input  logic             yng_vld_i,
  input  logic [2:0]       yng_cls_i,
  input  logic [REG_W-1:0] yng_dst_i,
  input  logic [REG_W-1:0] yng_src0_i,
  input  logic [REG_W-1:0] yng_src1_i,
  output logic             iss_old_o,
  output logic             iss_yng_o,
  output logic [1:0]       consume_o
);
  cls_e old_c, yng_c;
  logic cls_ok, raw, waw, go;

  assign old_c = decode_cls(old_cls_i);
  assign yng_c = decode_cls(yng_cls_i);

  dip_class_rule u_rule (
    .old_cls_i (old_c),
    .yng_cls_i (yng_c),
    .pair_ok_o (cls_ok)
  );

  dip_hazard #(.REG_W(REG_W)) u_haz (
    .old_wr_i   (writes_dst(old_c)),
    .old_dst_i  (old_dst_i),
    .yng_wr_i   (writes_dst(yng_c)),
    .yng_dst_i  (yng_dst_i),
    .yng_src0_i (yng_src0_i),
    .yng_src1_i (yng_src1_i),
    .raw_o      (raw),
    .waw_o      (waw)
  );

  assign go        = rst_ni && !stall_i && old_vld_i;
  assign iss_old_o = go;
  assign iss_yng_o = go && yng_vld_i && cls_ok && !raw && !waw;
  assign consume_o = {iss_yng_o, iss_old_o && !iss_yng_o};

  a_r1_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_yng_o |-> iss_old_o);
  a_r1_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_o != 2'd3);
  a_r2_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i || !old_vld_i) |-> (!iss_old_o && consume_o == 2'd0));
  a_r4_no_two_flow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_yng_o |-> !(is_flow(old_c) && is_flow(yng_c)));
  a_r5_call_not_older: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_yng_o |-> (old_c != CLS_CALL));
  a_r6_reg_alu_not_younger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_yng_o |-> (yng_c != CLS_ALU_REG));
  a_r7_other_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_yng_o |-> (old_c != CLS_OTHER && yng_c != CLS_OTHER));
  a_r8_raw_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_yng_o && old_c != CLS_BRANCH) |->
      (yng_src0_i != old_dst_i && yng_src1_i != old_dst_i));
endmodule

// File: tb/tb_dual_issue_pair.sv
`timescale 1ns/1ps
module tb_dual_issue_pair;
  localparam int RW = 5;
  localparam logic [2:0] OT = 3'd0, BR = 3'd1, CL = 3'd2, AI = 3'd3, AR = 3'd4;

  typedef struct packed {
    logic          v;
    logic [2:0]    c;
    logic [RW-1:0] d, s0, s1;
  } ins_t;

  logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
  ins_t o_in, y_in;
  logic iss_o, iss_y;
  logic [1:0] cons;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_issue_pair #(.REG_W(RW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
    .old_vld_i(o_in.v), .old_cls_i(o_in.c), .old_dst_i(o_in.d),
    .old_src0_i(o_in.s0), .old_src1_i(o_in.s1),
    .yng_vld_i(y_in.v), .yng_cls_i(y_in.c), .yng_dst_i(y_in.d),
    .yng_src0_i(y_in.s0), .yng_src1_i(y_in.s1),
    .iss_old_o(iss_o), .iss_yng_o(iss_y), .consume_o(cons)
  );

  function automatic ins_t mk(logic [2:0] c, logic [RW-1:0] d, logic [RW-1:0] s0, logic [RW-1:0] s1);
    return '{v: 1'b1, c: c, d: d, s0: s0, s1: s1};
  endfunction

  function automatic logic [2:0] norm(logic [2:0] c);
    return (c > 3'd4) ? OT : c;
  endfunction

  // independent reference of the pairing table
  function automatic logic table_ok(logic [2:0] oc, logic [2:0] yc);
    logic [2:0] a, b;
    a = norm(oc);
    b = norm(yc);
    if (a == OT || b == OT) return 1'b0;
    if ((a == BR || a == CL) && (b == BR || b == CL)) return 1'b0;
    if (a == CL) return 1'b0;
    if (b == AR) return 1'b0;
    if (a == AR) return b == AI;
    if (a == BR) return b == AI;
    return 1'b1;
  endfunction

  function automatic int ref_count(ins_t a, ins_t b, logic st);
    logic aw, bw;
    if (st || !a.v) return 0;
    if (!b.v || !table_ok(a.c, b.c)) return 1;
    aw = norm(a.c) != BR;
    bw = norm(b.c) != BR;
    if (aw && (b.s0 == a.d || b.s1 == a.d)) return 1;
    if (aw && bw && a.d == b.d) return 1;
    return 2;
  endfunction

  task automatic apply(ins_t a, ins_t b);
    @(negedge clk);
    o_in = a;
    y_in = b;
    #1;
  endtask

  task automatic check(string tag, int exp);
    logic [3:0] act, expv;
    act  = {iss_o, iss_y, cons};
    expv = {exp >= 1, exp == 2, 2'(exp)};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual iss_old=%b iss_yng=%b consume=%0d expected %b %b %0d",
               tag, iss_o, iss_y, cons, expv[3], expv[2], expv[1:0]);
    end
  endtask

  task automatic t_reset();
    apply(mk(AI, 1, 2, 3), mk(AI, 4, 5, 6));
    check("R2 reset", 0);
    rst_n = 1'b1;
    #1;
    check("R3 pair after reset", 2);
  endtask

  task automatic t_stall();
    stall = 1'b1;
    apply(mk(AI, 1, 2, 3), mk(AI, 4, 5, 6));
    check("R2 stall", 0);
    stall = 1'b0;
    apply('0, mk(AI, 4, 5, 6));
    check("R2 invalid older", 0);
    apply(mk(AI, 1, 2, 3), '0);
    check("R2 invalid younger", 1);
  endtask

  task automatic t_branch();
    apply(mk(BR, 9, 2, 3), mk(AI, 9, 5, 6));
    check("R3 branch older, dst ignored", 2);
    apply(mk(AI, 7, 2, 3), mk(BR, 0, 5, 6));
    check("R3 branch younger", 2);
    apply(mk(BR, 0, 2, 3), mk(BR, 1, 5, 6));
    check("R4 branch+branch", 1);
    apply(mk(BR, 0, 2, 3), mk(CL, 14, 5, 6));
    check("R4 branch+call", 1);
    apply(mk(CL, 14, 2, 3), mk(BR, 0, 5, 6));
    check("R4 call+branch", 1);
  endtask

  task automatic t_call();
    apply(mk(CL, 14, 2, 3), mk(AI, 4, 5, 6));
    check("R5 call older", 1);
    apply(mk(AI, 4, 2, 3), mk(CL, 14, 5, 6));
    check("R5 call younger", 2);
  endtask

  task automatic t_alu_reg();
    apply(mk(AR, 1, 2, 3), mk(AI, 4, 5, 6));
    check("R6 reg older imm younger", 2);
    apply(mk(AR, 1, 2, 3), mk(AR, 4, 5, 6));
    check("R6 reg+reg", 1);
    apply(mk(AI, 1, 2, 3), mk(AR, 4, 5, 6));
    check("R6 reg younger", 1);
    apply(mk(AR, 1, 2, 3), mk(BR, 0, 5, 6));
    check("R6 reg+branch", 1);
  endtask

  task automatic t_other();
    apply(mk(OT, 1, 2, 3), mk(AI, 4, 5, 6));
    check("R7 other older", 1);
    apply(mk(AI, 1, 2, 3), mk(OT, 4, 5, 6));
    check("R7 other younger", 1);
    apply(mk(AI, 1, 2, 3), mk(3'd6, 4, 5, 6));
    check("R7 unknown code", 1);
  endtask

  task automatic t_deps();
    apply(mk(AI, 8, 2, 3), mk(AI, 4, 8, 6));
    check("R8 raw src0", 1);
    apply(mk(AR, 8, 2, 3), mk(AI, 4, 5, 8));
    check("R8 raw src1", 1);
    apply(mk(AI, 8, 2, 3), mk(BR, 0, 8, 6));
    check("R8 branch reads result", 1);
    apply(mk(AI, 8, 2, 3), mk(AI, 8, 5, 6));
    check("R9 waw", 1);
    apply(mk(AI, 8, 2, 3), mk(BR, 8, 5, 6));
    check("R9 younger branch no write", 2);
  endtask

  // bench-side decode buffer advancing by consume_o
  task automatic t_advance();
    ins_t prog [6];
    int head;
    int exp_seq [4] = '{1, 2, 1, 2};
    prog[0] = mk(AR, 1, 2, 3);
    prog[1] = mk(AI, 4, 1, 5);
    prog[2] = mk(AI, 6, 7, 7);
    prog[3] = mk(CL, 14, 2, 2);
    prog[4] = mk(AI, 9, 14, 3);
    prog[5] = mk(AI, 10, 11, 12);
    head = 0;
    for (int k = 0; k < 4; k++) begin
      apply(prog[head], prog[head+1]);
      check($sformatf("R10 step %0d", k), exp_seq[k]);
      head += int'(cons);
    end
    checks++;
    if (head != 6) begin
      errors++;
      $display("FAIL R10 head actual %0d expected 6", head);
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      ins_t a, b;
      logic st;
      a = '{v: ($urandom % 8) != 0, c: 3'($urandom), d: RW'($urandom % 6),
            s0: RW'($urandom % 6), s1: RW'($urandom % 6)};
      b = '{v: ($urandom % 8) != 0, c: 3'($urandom), d: RW'($urandom % 6),
            s0: RW'($urandom % 6), s1: RW'($urandom % 6)};
      st = ($urandom % 10) == 0;
      stall = st;
      apply(a, b);
      check("R1 random vs table", ref_count(a, b, st));
    end
    stall = 1'b0;
  endtask

  initial begin
    o_in = '0;
    y_in = '0;
    t_reset();
    t_stall();
    t_branch();
    t_call();
    t_alu_reg();
    t_other();
    t_deps();
    t_advance();
    t_random();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule